// File: doc/BRIEF.md
# Counter Array Timebase

This block is the shared 16-bit timebase behind a microcontroller's bank of compare/capture units. A mode register picks what advances the count: one of two internal prescales of the core clock, a one-cycle overflow pulse from a neighbouring timer, or falling edges on an external count pin. A double-speed input halves both internal prescales. A run bit starts and stops counting. An idle-gate bit, when set, freezes the count while the chip's idle input is high.

When the count wraps from all ones to zero, a sticky overflow flag is set. That flag raises the interrupt request only while its enable bit is set. The mode register also stores a watchdog-enable bit that drives a compare unit downstream. Software reaches the control register, the mode register and the two count bytes through a byte-wide special-function-register port. Writes take effect on the clock edge, and reads are combinational from the address. The count bytes are also driven out continuously for the compare units.

Top module: `pca_timebase`

## Requirements
- R1: After reset, the mode register, the control register and both count bytes read 0x00, and the interrupt request and the watchdog enable are low.
- R2: With source code 00 (mode bits 2:1), the count advances once every 12 clock cycles. With the double-speed input high, it advances once every 6.
- R3: With source code 01, the count advances once every 4 clock cycles. With the double-speed input high, it advances once every 2.
- R4: With source code 10, each one-cycle timer-overflow pulse advances the count by exactly one.
- R5: With source code 11, each falling edge on the external pin is counted once. The pin is synchronized and sampled every 4 clocks, so the count advances at most once per 8 clocks.
- R6: The count advances only while the run bit (control bit 6) is 1.
- R7: When the idle-gate bit (mode bit 7) is 1, the count is frozen while the idle input is high. When it is 0, counting continues in idle.
- R8: A wrap from 0xFFFF to 0x0000 sets the overflow flag (control bit 7).
- R9: The overflow flag is cleared only by a control write with bit 7 = 0. Writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves it set.
- R10: The interrupt request is high exactly while the overflow flag and the interrupt enable (mode bit 0) are both 1.
- R11: Mode bit 6 is stored and drives the watchdog-enable output.
- R12: Mode bits 5:3 and control bits 5:0 ignore writes and read as 0. The register addresses are control 0xD8, mode 0xD9, count low 0xE9 and count high 0xF9. Any other address reads 0x00.
- R13: A write to a count byte loads that byte directly, takes priority over a count step in the same cycle, and never sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x2_mode_i | input | 1 | Double-speed mode, halves the internal prescales |
| idle_i | input | 1 | Chip idle state |
| t0_ovf_i | input | 1 | One-cycle overflow pulse from the neighbouring timer |
| eci_i | input | 1 | External count pin, asynchronous |
| sfr_addr_i | input | 8 | Register address |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data for sfr_addr_i |
| cnt_lo_o | output | 8 | Count, low byte |
| cnt_hi_o | output | 8 | Count, high byte |
| wdt_en_o | output | 1 | Watchdog enable for the downstream compare unit |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench measures the spacing between count steps for each internal prescale, in both normal and double-speed mode. A design with the wrong divider, or one that ignores the double-speed input, shows the wrong spacing. It drives the external pin both at a legal rate and far too fast. An edge detector that counts both edges would overcount the legal stream, and a missing rate limit would let the fast stream through. It lines up a clearing write with a wrapping timer pulse in the same cycle. It also loads 0xFFFF through the count bytes. The first case catches a design that lets the clear win, and the second catches a design that raises the flag on a software load. Idle gating, the run bit and interrupt masking are each toggled while the count is watched, which exposes a gate tied to the wrong bit.

// File: rtl/pca_tmb_pkg.sv
package pca_tmb_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  localparam int unsigned BYTE_W = 8;

  // positions decoded by software
  localparam int unsigned MODE_IDLE_GATE = 7;
  localparam int unsigned MODE_WDT       = 6;
  localparam int unsigned MODE_SRC_HI    = 2;
  localparam int unsigned MODE_SRC_LO    = 1;
  localparam int unsigned MODE_IRQ_EN    = 0;
  localparam int unsigned CTRL_FLAG      = 7;
  localparam int unsigned CTRL_RUN       = 6;

endpackage

// File: rtl/pca_prescale.sv
module pca_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halve_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LIM_FULL = W'(DIV - 1);
  localparam logic [W-1:0] LIM_HALF = W'(DIV / 2 - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim    = halve_i ? LIM_HALF : LIM_FULL;
  // >= keeps the counter in range when halve_i changes mid-period
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pca_tick_gen.sv
module pca_tick_gen
  import pca_tmb_pkg::*;
#(
  parameter int unsigned DIV_SLOW    = 12,
  parameter int unsigned DIV_FAST    = 4,
  parameter int unsigned ECI_SMP_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x2_mode_i,
  input  src_e src_i,
  input  logic t0_ovf_i,
  input  logic eci_i,
  output logic tick_o
);
  localparam int unsigned NPRE = 3;
  localparam int unsigned DIVS [NPRE] = '{DIV_SLOW, DIV_FAST, ECI_SMP_DIV};
  localparam int unsigned GAP_MIN = 2 * ECI_SMP_DIV - 1;
  localparam int unsigned GAP_W   = $clog2(GAP_MIN + 1);

  logic [NPRE-1:0] pre_tick;

  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    // pin sampling strobe is never halved
    pca_prescale #(.DIV(DIVS[g])) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .halve_i ((g < 2) ? x2_mode_i : 1'b0),
      .tick_o  (pre_tick[g])
    );
  end

  logic eci_s1_q, eci_s2_q, eci_smp_q;
  logic eci_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eci_s1_q  <= 1'b1;
      eci_s2_q  <= 1'b1;
      eci_smp_q <= 1'b1;
    end else begin
      eci_s1_q <= eci_i;
      eci_s2_q <= eci_s1_q;
      if (pre_tick[2]) eci_smp_q <= eci_s2_q;
    end
  end

  // fall between two successive strobe samples
  assign eci_tick = pre_tick[2] && eci_smp_q && !eci_s2_q;

  always_comb begin
    unique case (src_i)
      SRC_SLOW: tick_o = pre_tick[0];
      SRC_FAST: tick_o = pre_tick[1];
      SRC_TMR:  tick_o = t0_ovf_i;
      default:  tick_o = eci_tick;
    endcase
  end

  // cycles since last pin event, saturating
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= GAP_W'(GAP_MIN);
    else if (eci_tick)               gap_q <= '0;
    else if (gap_q != GAP_W'(GAP_MIN)) gap_q <= gap_q + 1'b1;
  end

  AST_ECI_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eci_tick |-> (gap_q == GAP_W'(GAP_MIN))); // R5

endmodule

// File: rtl/pca_count16.sv
module pca_count16
  import pca_tmb_pkg::*;
#(
  parameter int unsigned NBYTES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     inc_i,
  input  logic [NBYTES-1:0]        ld_i,
  input  logic [BYTE_W-1:0]        ld_data_i,
  output logic [NBYTES*BYTE_W-1:0] cnt_o,
  output logic                     wrap_o
);
  localparam int unsigned W = NBYTES * BYTE_W;

  logic [W-1:0] cnt_q;
  logic         any_ld;

  assign any_ld = |ld_i;
  assign wrap_o = inc_i && !any_ld && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (any_ld) begin
      for (int b = 0; b < NBYTES; b++)
        if (ld_i[b]) cnt_q[b*BYTE_W +: BYTE_W] <= ld_data_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !any_ld) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !any_ld) |=> $stable(cnt_q)); // R6
  AST_LOAD_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld |-> !wrap_o); // R13

endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_tmb_pkg::*;
#(
  parameter logic [7:0]  ADDR_CTRL   = 8'hD8,
  parameter logic [7:0]  ADDR_MODE   = 8'hD9,
  parameter logic [7:0]  ADDR_CNT_LO = 8'hE9,
  parameter logic [7:0]  ADDR_CNT_HI = 8'hF9,
  parameter int unsigned DIV_SLOW    = 12,
  parameter int unsigned DIV_FAST    = 4,
  parameter int unsigned ECI_SMP_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       x2_mode_i,
  input  logic       idle_i,
  input  logic       t0_ovf_i,
  input  logic       eci_i,
  input  logic [7:0] sfr_addr_i,
  input  logic       sfr_we_i,
  input  logic [7:0] sfr_wdata_i,
  output logic [7:0] sfr_rdata_o,
  output logic [7:0] cnt_lo_o,
  output logic [7:0] cnt_hi_o,
  output logic       wdt_en_o,
  output logic       irq_o
);
  localparam int unsigned NBYTES = 2;

  logic idle_gate_q, wdt_q, irq_en_q, run_q, flag_q;
  src_e src_q;

  logic wr_mode, wr_ctrl, flag_clr;
  logic [NBYTES-1:0] ld;
  logic src_tick, count_en, wrap;
  logic [NBYTES*BYTE_W-1:0] cnt;

  assign wr_mode  = sfr_we_i && (sfr_addr_i == ADDR_MODE);
  assign wr_ctrl  = sfr_we_i && (sfr_addr_i == ADDR_CTRL);
  assign ld[0]    = sfr_we_i && (sfr_addr_i == ADDR_CNT_LO);
  assign ld[1]    = sfr_we_i && (sfr_addr_i == ADDR_CNT_HI);
  assign flag_clr = wr_ctrl && !sfr_wdata_i[CTRL_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_gate_q <= 1'b0;
      wdt_q       <= 1'b0;
      src_q       <= SRC_SLOW;
      irq_en_q    <= 1'b0;
    end else if (wr_mode) begin
      idle_gate_q <= sfr_wdata_i[MODE_IDLE_GATE];
      wdt_q       <= sfr_wdata_i[MODE_WDT];
      src_q       <= src_e'({sfr_wdata_i[MODE_SRC_HI], sfr_wdata_i[MODE_SRC_LO]});
      irq_en_q    <= sfr_wdata_i[MODE_IRQ_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= sfr_wdata_i[CTRL_RUN];
      // a wrap beats a clearing write
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  pca_tick_gen #(
    .DIV_SLOW    (DIV_SLOW),
    .DIV_FAST    (DIV_FAST),
    .ECI_SMP_DIV (ECI_SMP_DIV)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x2_mode_i (x2_mode_i),
    .src_i     (src_q),
    .t0_ovf_i  (t0_ovf_i),
    .eci_i     (eci_i),
    .tick_o    (src_tick)
  );

  assign count_en = run_q && src_tick && !(idle_gate_q && idle_i);

  pca_count16 #(.NBYTES(NBYTES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (count_en),
    .ld_i      (ld),
    .ld_data_i (sfr_wdata_i),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  assign cnt_lo_o = cnt[BYTE_W-1:0];
  assign cnt_hi_o = cnt[2*BYTE_W-1:BYTE_W];
  assign wdt_en_o = wdt_q;
  assign irq_o    = flag_q && irq_en_q;

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_addr_i == ADDR_MODE) begin
      sfr_rdata_o[MODE_IDLE_GATE] = idle_gate_q;
      sfr_rdata_o[MODE_WDT]       = wdt_q;
      sfr_rdata_o[MODE_SRC_HI]    = src_q[1];
      sfr_rdata_o[MODE_SRC_LO]    = src_q[0];
      sfr_rdata_o[MODE_IRQ_EN]    = irq_en_q;
    end else if (sfr_addr_i == ADDR_CTRL) begin
      sfr_rdata_o[CTRL_FLAG] = flag_q;
      sfr_rdata_o[CTRL_RUN]  = run_q;
    end else if (sfr_addr_i == ADDR_CNT_LO) begin
      sfr_rdata_o = cnt_lo_o;
    end else if (sfr_addr_i == ADDR_CNT_HI) begin
      sfr_rdata_o = cnt_hi_o;
    end
  end

  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o); // R10
  AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_gate_q && idle_i && !(|ld)) |=> $stable(cnt)); // R7
  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(|ld)) |=> $stable(cnt)); // R6
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == ADDR_MODE) |-> (sfr_rdata_o[5:3] == 3'b000)); // R12

endmodule

// File: tb/pca_timebase_tb.sv
module pca_timebase_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x2 = 1'b0, idle = 1'b0, t0 = 1'b0, eci = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata, cnt_lo, cnt_hi;
  logic       wdt_en, irq;

  always #5 clk = ~clk;

  pca_timebase dut_i (
    .clk_i(clk), .rst_ni(rst_n), .x2_mode_i(x2), .idle_i(idle),
    .t0_ovf_i(t0), .eci_i(eci), .sfr_addr_i(addr), .sfr_we_i(we),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .cnt_lo_o(cnt_lo),
    .cnt_hi_o(cnt_hi), .wdt_en_o(wdt_en), .irq_o(irq)
  );

  typedef struct { string tag; int act; int exp; } item_t;
  item_t sb_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor: pops and compares queued items
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (it.act != it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic expect_val(input string tag, input int act, input int exp);
    item_t it;
    it.tag = tag; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic period(output int n);
    logic [7:0] s;
    s = cnt_lo;
    do @(negedge clk); while (cnt_lo == s);
    s = cnt_lo; n = 0;
    do begin @(negedge clk); n++; end while (cnt_lo == s);
  endtask

  task automatic delta_over(input int cycles, output int d);
    logic [15:0] s;
    @(negedge clk);
    s = {cnt_hi, cnt_lo};
    repeat (cycles) @(negedge clk);
    d = int'(16'({cnt_hi, cnt_lo} - s));
  endtask

  task automatic t0_pulse();
    @(negedge clk); t0 = 1'b1;
    @(negedge clk); t0 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'hD9, v); expect_val("R1 mode", v, 8'h00);
    rd(8'hD8, v); expect_val("R1 ctrl", v, 8'h00);
    rd(8'hE9, v); expect_val("R1 cnt lo", v, 8'h00);
    rd(8'hF9, v); expect_val("R1 cnt hi", v, 8'h00);
    expect_val("R1 irq", irq, 0);
    expect_val("R1 wdt", wdt_en, 0);

    // R12 reserved bits, unmapped address; R11 watchdog enable
    wr(8'hD9, 8'hFF);
    rd(8'hD9, v); expect_val("R12 mode readback", v, 8'hC7);
    expect_val("R11 wdt on", wdt_en, 1);
    wr(8'hD8, 8'h3F);
    rd(8'hD8, v); expect_val("R12 ctrl readback", v, 8'h00);
    rd(8'h55, v); expect_val("R12 unmapped", v, 8'h00);
    wr(8'hD9, 8'h00);
    expect_val("R11 wdt off", wdt_en, 0);

    // R6 stopped with a fast source
    wr(8'hD9, 8'h02);
    delta_over(40, n); expect_val("R6 no count when stopped", n, 0);

    // R3 / R2 prescale periods
    wr(8'hD8, 8'h40);
    period(n); expect_val("R3 fast period", n, 4);
    wr(8'hD9, 8'h00);
    period(n); period(n); expect_val("R2 slow period", n, 12);
    x2 = 1'b1;
    period(n); period(n); expect_val("R2 slow period x2", n, 6);
    wr(8'hD9, 8'h02);
    period(n); period(n); expect_val("R3 fast period x2", n, 2);
    x2 = 1'b0;

    // R7 idle gating
    wr(8'hD9, 8'h82);
    @(negedge clk); idle = 1'b1;
    delta_over(40, n); expect_val("R7 frozen in idle", n, 0);
    wr(8'hD9, 8'h02);
    delta_over(40, n); expect_val("R7 counts in idle when ungated", n, 10);
    @(negedge clk); idle = 1'b0;

    // R4 timer overflow source
    wr(8'hD9, 8'h04);
    wr(8'hE9, 8'h00); wr(8'hF9, 8'h00);
    repeat (5) t0_pulse();
    expect_val("R4 timer pulses", {cnt_hi, cnt_lo}, 5);

    // R5 pin source, legal rate: 10 falls, period 16
    wr(8'hD9, 8'h06);
    wr(8'hE9, 8'h00);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); eci = 1'b0;
      repeat (8) @(negedge clk);
      eci = 1'b1;
      repeat (7) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    expect_val("R5 pin falls counted once", {cnt_hi, cnt_lo}, 10);
    // R5 too fast: period 4
    wr(8'hE9, 8'h00);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); eci = 1'b0;
      @(negedge clk);
      @(negedge clk); eci = 1'b1;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    expect_val("R5 rate limit", int'(cnt_lo <= 8'd10), 1);

    // R13 load of all ones does not flag
    wr(8'hD9, 8'h04);
    wr(8'hF9, 8'hFF); wr(8'hE9, 8'hFF);
    rd(8'hD8, v); expect_val("R13 load no flag", v, 8'h40);
    expect_val("R13 loaded value", {cnt_hi, cnt_lo}, 16'hFFFF);

    // R8 wrap sets flag; R10 masking
    t0_pulse();
    expect_val("R8 wrapped count", {cnt_hi, cnt_lo}, 0);
    rd(8'hD8, v); expect_val("R8 flag set", v, 8'hC0);
    expect_val("R10 masked irq", irq, 0);
    wr(8'hD9, 8'h05);
    expect_val("R10 irq raised", irq, 1);

    // R9 sticky flag
    wr(8'hD8, 8'hC0);
    rd(8'hD8, v); expect_val("R9 write one keeps flag", v, 8'hC0);
    wr(8'hD8, 8'h40);
    rd(8'hD8, v); expect_val("R9 write zero clears", v, 8'h40);
    expect_val("R10 irq drops", irq, 0);
    wr(8'hF9, 8'hFF); wr(8'hE9, 8'hFF);
    @(negedge clk);
    addr = 8'hD8; wdata = 8'h40; we = 1'b1; t0 = 1'b1;
    @(negedge clk);
    we = 1'b0; t0 = 1'b0;
    rd(8'hD8, v); expect_val("R9 wrap beats clear", v, 8'hC0);
    expect_val("R10 irq after race", irq, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule